// File: doc/BRIEF.md
# Segment-Table Address Translator

This block turns a logical address, made of a segment number and an offset inside that segment, into a physical address. It holds a small table with one entry per segment. Each entry has a base physical address, a segment length and a valid bit. For each accepted request, the block looks up the entry and checks the offset against the entry's length. It then returns either base plus offset or a trap flag. A trap is raised for an offset that is too large, for a segment number past the table, and for an entry that is not valid.

The table is loaded through a plain write port. Any number of entries may hold the same base, so two address spaces can map onto one shared region. Requests enter on a valid/ready handshake. Results leave on a second valid/ready handshake, one cycle after acceptance, and a new request can be taken every cycle.

Back-pressure rules:
- `req_ready` is high whenever the output slot is empty or is being drained in the same cycle.
- While `rsp_valid` is high and `rsp_ready` is low, the result holds still and no request is taken.

Top module: `seg_xlate`

## Requirements
- R1: After reset every table entry is invalid, `rsp_valid` is 0 and `req_ready` is 1, so any request returns a trap.
- R2: A request accepted with a valid entry and an offset below that entry's length yields, on the next cycle, `rsp_valid`=1, `rsp_fault`=0 and `rsp_addr` = base + offset.
- R3: An offset equal to or above the entry's length yields `rsp_fault`=1 and `rsp_addr`=0. Offset length-1 is still legal.
- R4: A segment number equal to or above NUM_SEG (default 6) yields `rsp_fault`=1 and `rsp_addr`=0.
- R5: A table write changes the result only for requests accepted on a later cycle. A request accepted in the write's own cycle sees the old entry.
- R6: Several entries may hold the same base, and each translates against it independently.
- R7: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and `rsp_addr`/`rsp_fault` stay unchanged.
- R8: With `rsp_ready` held high, back-to-back requests are accepted every cycle, each result one cycle later. `rsp_valid` never rises without an accepted request.
- R9: A write with `wr_valid`=0 invalidates the entry, so later requests to that segment trap.
- R10: A write whose `wr_seg` is NUM_SEG or above changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_seg | input | SEG_W | Entry index to write |
| wr_base | input | PA_W | Base physical address to store |
| wr_len | input | OFF_W+1 | Segment length to store |
| wr_valid | input | 1 | Valid bit to store |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_seg | input | SEG_W | Logical segment number |
| req_off | input | OFF_W | Offset in segment |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | PA_W | Physical address, 0 on a trap |
| rsp_fault | output | 1 | Trap flag |

## Verification
Two functions can fall in the same cycle: a table write and a lookup of that same entry. The bench provokes this by raising `wr_en` and `req_valid` for one segment in a single cycle, then sending the identical request again on the next cycle. The first result must show the old entry, which is an invalid trap. The second must show the new base plus offset. A second overlap is a held result under back-pressure while a new request waits. It is judged by checking the held payload over several cycles and then the order in which both results drain.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned SEG_W_DEF   = 3;
  localparam int unsigned NUM_SEG_DEF = 6;
  localparam int unsigned OFF_W_DEF   = 12;
  localparam int unsigned PA_W_DEF    = 16;

  typedef enum logic {
    XL_PASS = 1'b0,
    XL_TRAP = 1'b1
  } xl_status_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int unsigned SEG_W   = 3,
  parameter int unsigned NUM_SEG = 6,
  parameter int unsigned PA_W    = 16,
  parameter int unsigned LEN_W   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [LEN_W-1:0] wr_len,
  input  logic             wr_valid,
  input  logic [SEG_W-1:0] rd_seg,
  output logic [PA_W-1:0]  rd_base,
  output logic [LEN_W-1:0] rd_len,
  output logic             rd_hit
);
  logic [PA_W-1:0]  base_arr [NUM_SEG];
  logic [LEN_W-1:0] len_arr  [NUM_SEG];
  logic [NUM_SEG-1:0] vld_vec;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    logic             sel_w;
    logic             vld_q;
    logic [PA_W-1:0]  base_q;
    logic [LEN_W-1:0] len_q;

    assign sel_w = wr_en && (wr_seg == SEG_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        base_q <= '0;
        len_q  <= '0;
      end else if (sel_w) begin
        vld_q  <= wr_valid;
        base_q <= wr_base;
        len_q  <= wr_len;
      end
    end

    assign base_arr[g] = base_q;
    assign len_arr[g]  = len_q;
    assign vld_vec[g]  = vld_q;
  end

  always_comb begin
    rd_base = '0;
    rd_len  = '0;
    rd_hit  = 1'b0;
    for (int e = 0; e < NUM_SEG; e++) begin
      if (rd_seg == SEG_W'(e)) begin
        rd_base = base_arr[e];
        rd_len  = len_arr[e];
        rd_hit  = vld_vec[e];
      end
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PA_W  = 16,
  parameter int unsigned LEN_W = OFF_W + 1
) (
  input  logic             hit,
  input  logic [PA_W-1:0]  base,
  input  logic [LEN_W-1:0] len,
  input  logic [OFF_W-1:0] off,
  output xl_status_e       status,
  output logic [PA_W-1:0]  addr
);
  localparam int unsigned PAD_W = PA_W - OFF_W;

  logic             over_w;
  logic [PA_W-1:0]  off_ext;

  assign over_w  = {1'b0, off} >= len;
  assign off_ext = {{PAD_W{1'b0}}, off};

  always_comb begin
    if (!hit || over_w) begin
      status = XL_TRAP;
      addr   = '0;
    end else begin
      status = XL_PASS;
      addr   = base + off_ext;
    end
  end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import seg_xlate_pkg::*;
#(
  parameter int unsigned PA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  xl_status_e      in_status,
  input  logic [PA_W-1:0] in_addr,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_fault,
  output logic [PA_W-1:0] out_addr
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_addr  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_fault <= (in_status == XL_TRAP);
        out_addr  <= in_addr;
      end
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_W   = SEG_W_DEF,
  parameter int unsigned NUM_SEG = NUM_SEG_DEF,
  parameter int unsigned OFF_W   = OFF_W_DEF,
  parameter int unsigned PA_W    = PA_W_DEF,
  localparam int unsigned LEN_W  = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [LEN_W-1:0] wr_len,
  input  logic             wr_valid,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_addr,
  output logic             rsp_fault
);
  logic [PA_W-1:0]  tb_base;
  logic [LEN_W-1:0] tb_len;
  logic             tb_hit;
  xl_status_e       ck_status;
  logic [PA_W-1:0]  ck_addr;

  seg_table #(
    .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .PA_W(PA_W), .LEN_W(LEN_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_seg(wr_seg), .wr_base(wr_base),
    .wr_len(wr_len), .wr_valid(wr_valid),
    .rd_seg(req_seg), .rd_base(tb_base), .rd_len(tb_len), .rd_hit(tb_hit)
  );

  seg_check #(
    .OFF_W(OFF_W), .PA_W(PA_W), .LEN_W(LEN_W)
  ) u_check (
    .hit(tb_hit), .base(tb_base), .len(tb_len), .off(req_off),
    .status(ck_status), .addr(ck_addr)
  );

  seg_out_stage #(
    .PA_W(PA_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_status(ck_status), .in_addr(ck_addr),
    .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_fault(rsp_fault), .out_addr(rsp_addr)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned SEG_W   = 3,
  parameter int unsigned NUM_SEG = 6,
  parameter int unsigned PA_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [SEG_W-1:0] req_seg,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_addr,
  input logic             rsp_fault
);
  localparam logic [SEG_W:0] SEG_LIM = (SEG_W+1)'(NUM_SEG);

  logic acc_w, stall_w;
  assign acc_w   = req_valid && req_ready;
  assign stall_w = rsp_valid && !rsp_ready;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault));

  assert_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |-> !req_ready);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w |=> rsp_valid);

  assert_trap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_addr == '0));

  assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w && ({1'b0, req_seg} >= SEG_LIM)) |=> rsp_fault);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_w && !stall_w) |=> !rsp_valid);
endmodule

bind seg_xlate seg_xlate_chk #(
  .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .PA_W(PA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
);

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;
  localparam int SEG_W = 3;
  localparam int OFF_W = 12;
  localparam int PA_W  = 16;
  localparam int LEN_W = OFF_W + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [SEG_W-1:0] wr_seg = '0;
  logic [PA_W-1:0]  wr_base = '0;
  logic [LEN_W-1:0] wr_len = '0;
  logic             wr_valid = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic             rsp_valid;
  logic             rsp_ready = 1'b1;
  logic [PA_W-1:0]  rsp_addr;
  logic             rsp_fault;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_xlate dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_seg(wr_seg), .wr_base(wr_base),
    .wr_len(wr_len), .wr_valid(wr_valid),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tbl_write(input int seg, input int base, input int len, input bit v);
    @(negedge clk);
    wr_en = 1'b1; wr_seg = SEG_W'(seg); wr_base = PA_W'(base);
    wr_len = LEN_W'(len); wr_valid = v;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic xlate(input string tag, input int seg, input int off,
                       input bit exp_fault, input int exp_addr);
    @(negedge clk);
    req_valid = 1'b1; req_seg = SEG_W'(seg); req_off = OFF_W'(off);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, int'(rsp_valid), 1);
    chk({tag, " fault"}, int'(rsp_fault), int'(exp_fault));
    chk({tag, " addr"}, int'(rsp_addr), exp_addr);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1 req_ready after reset", int'(req_ready), 1);
    xlate("R1 empty table", 0, 0, 1'b1, 0);
  endtask

  task automatic load_table();
    tbl_write(0, 219, 600, 1'b1);
    tbl_write(1, 2300, 14, 1'b1);
    tbl_write(2, 90, 100, 1'b1);
    tbl_write(3, 1327, 580, 1'b1);
    tbl_write(4, 1952, 96, 1'b1);
  endtask

  task automatic test_basic();
    xlate("R2 seg0 off430", 0, 430, 1'b0, 649);
    xlate("R2 seg1 off10", 1, 10, 1'b0, 2310);
    xlate("R2 seg3 off400", 3, 400, 1'b0, 1727);
    xlate("R3 seg2 off500", 2, 500, 1'b1, 0);
    xlate("R3 seg4 off112", 4, 112, 1'b1, 0);
  endtask

  task automatic test_bounds();
    xlate("R3 last legal", 1, 13, 1'b0, 2313);
    xlate("R3 equal len", 1, 14, 1'b1, 0);
    xlate("R4 invalid seg5", 5, 0, 1'b1, 0);
    xlate("R4 seg6 out of range", 6, 1, 1'b1, 0);
    xlate("R4 seg7 out of range", 7, 1, 1'b1, 0);
  endtask

  task automatic test_same_cycle();
    @(negedge clk);
    wr_en = 1'b1; wr_seg = 3'd5; wr_base = 16'd4000; wr_len = 13'd50; wr_valid = 1'b1;
    req_valid = 1'b1; req_seg = 3'd5; req_off = 12'd10;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R5 same-cycle sees old", int'(rsp_fault), 1);
    chk("R5 same-cycle valid", int'(rsp_valid), 1);
    chk("R8 accepted back to back", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 next-cycle sees new fault", int'(rsp_fault), 0);
    chk("R5 next-cycle sees new addr", int'(rsp_addr), 4010);
    @(posedge clk);
    @(negedge clk);
    chk("R8 valid drops when idle", int'(rsp_valid), 0);
  endtask

  task automatic test_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_seg = 3'd0; req_off = 12'd430;
    @(posedge clk);
    @(negedge clk);
    req_seg = 3'd1; req_off = 12'd10;
    chk("R7 first result addr", int'(rsp_addr), 649);
    chk("R7 ready low while stalled", int'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 held valid", int'(rsp_valid), 1);
    chk("R7 held addr", int'(rsp_addr), 649);
    chk("R7 held fault", int'(rsp_fault), 0);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 second result after drain", int'(rsp_addr), 2310);
    chk("R7 second valid", int'(rsp_valid), 1);
    @(posedge clk);
  endtask

  task automatic test_shared_base();
    tbl_write(5, 219, 600, 1'b1);
    xlate("R6 shared base seg5", 5, 430, 1'b0, 649);
    xlate("R6 shared base seg0", 0, 430, 1'b0, 649);
  endtask

  task automatic test_invalidate();
    tbl_write(3, 1327, 580, 1'b0);
    xlate("R9 invalidated seg3", 3, 400, 1'b1, 0);
    xlate("R9 other entry intact", 4, 95, 1'b0, 2047);
  endtask

  task automatic test_oob_write();
    tbl_write(7, 0, 100, 1'b1);
    tbl_write(6, 0, 100, 1'b1);
    xlate("R10 seg7 still traps", 7, 5, 1'b1, 0);
    xlate("R10 seg6 still traps", 6, 5, 1'b1, 0);
    xlate("R10 seg0 unchanged", 0, 599, 1'b0, 818);
    xlate("R10 seg2 unchanged", 2, 99, 1'b0, 189);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    load_table();
    test_basic();
    test_bounds();
    test_same_cycle();
    test_backpressure();
    test_shared_base();
    test_invalidate();
    test_oob_write();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule